// File: doc/BRIEF.md
# Shared-Datapath Cascaded Biquad Filter Engine

This block runs a bank of second-order recursive filter sections over several audio channels with one multiply-accumulate unit. On every accepted sample strobe it captures one input word per channel and then walks the channels one after another. Inside each channel it walks that channel's cascaded sections in order. Each section is a direct-form-I biquad that keeps its own two past inputs and two past outputs. The result of one section is the input of the next section of the same channel. The last section's result becomes that channel's output word. The new output vector is published all at once.

Each channel has one set of five coefficients, shared by all of its sections, so a channel forms a cascade of identical biquads. Software-side logic writes coefficients into a shadow copy. The whole shadow copy becomes active only when a sample strobe is accepted, so a sample never sees a half-updated set. A walk over the default configuration takes a few tens of cycles, which is far inside a budget of several thousand clocks per audio sample.

Top module: `biquad_engine`

## Requirements
- R1: After reset, out_vec, busy, out_valid and overrun are all zero, every section's past inputs and outputs are zero, and every coefficient is zero.
- R2: A section computes acc = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2 in full precision. Coefficients are signed two's complement with FRAC (default 14) fraction bits. The section output is acc arithmetically shifted right by FRAC bits (rounding toward minus infinity). Coefficient select codes are 0=b0, 1=b1, 2=b2, 3=a1, 4=a2.
- R3: Within one sample, section 0 of a channel takes that channel's input word, and section s>0 takes the output of section s−1 of the same channel produced in the same sample. The channel's output word is the output of its last section.
- R4: A section output outside the signed DW-bit range is clamped to the largest or smallest DW-bit value. The clamped value is also what the section stores as its past output.
- R5: A write with cfg_we high updates only the shadow coefficient for cfg_ch and cfg_sel. All shadow values become active together at the next accepted sample strobe. Writes made while a walk is in progress do not affect that walk. Select codes 5 to 7 are ignored.
- R6: A strobe with busy low is accepted. busy is high for exactly NCH·NSEC·6+1 cycles, starting in the cycle after the accepted strobe. out_valid is a one-cycle pulse in the cycle busy falls, and out_vec changes only in that cycle.
- R7: A strobe arriving while busy is high is ignored and does not disturb the walk in progress. overrun is high for one cycle, in the cycle after that strobe.
- R8: Channels are independent: each has its own coefficient set and section state. Channel c occupies bits [c·DW +: DW] of in_vec and out_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Sample strobe |
| in_vec | input | NCH·DW | Signed input word per channel |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_ch | input | CHW | Channel of the coefficient write |
| cfg_sel | input | 3 | Coefficient select code |
| cfg_val | input | CW | Signed coefficient value |
| out_vec | output | NCH·DW | Signed output word per channel |
| out_valid | output | 1 | One-cycle pulse when out_vec is refreshed |
| busy | output | 1 | Walk over channels and sections in progress |
| overrun | output | 1 | One-cycle pulse after a strobe rejected while busy |

## Verification
A wrong past-sample register, a swapped section order or a stale coefficient has no effect on the current sample alone. It shows up in the following samples, once the recursion feeds it back. For that reason the bench compares every output of long runs of samples against an arithmetic model, and flags a mismatch within one or two samples of the fault. A wrong slot or step counter shows at once in the length of the busy window and in the timing of the out_valid pulse. A shadow copy that leaks into the active set shows in the very sample during which the write was made.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  // Sequencer step: five multiply-accumulate steps, then a write-back step.
  // The code of each MAC step equals the coefficient select code it uses.
  typedef enum logic [2:0] {
    ST_B0 = 3'd0,
    ST_B1 = 3'd1,
    ST_B2 = 3'd2,
    ST_A1 = 3'd3,
    ST_A2 = 3'd4,
    ST_WB = 3'd5
  } step_e;

  localparam int unsigned NCOEF = 5;
  localparam int unsigned STEPS_PER_SECTION = 6;
endpackage

// File: rtl/biquad_coef_bank.sv
module biquad_coef_bank #(
  parameter int NCH = 2,
  parameter int CW  = 18,
  parameter int CHW = 1
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 wr_en,
  input  logic [CHW-1:0]       wr_ch,
  input  logic [2:0]           wr_sel,
  input  logic signed [CW-1:0] wr_val,
  input  logic                 commit,
  input  logic [CHW-1:0]       rd_ch,
  input  logic [2:0]           rd_sel,
  output logic signed [CW-1:0] rd_val
);
  logic signed [CW-1:0] shadow_q [NCH][8];
  logic signed [CW-1:0] active_q [NCH][8];
  logic                 wr_ok;

  assign wr_ok  = wr_en && (int'(wr_sel) < int'(biquad_pkg::NCOEF));
  assign rd_val = active_q[rd_ch][rd_sel];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < 8; k++) shadow_q[c][k] <= '0;
    end else if (wr_ok) begin
      shadow_q[wr_ch][wr_sel] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NCH; c++)
        for (int k = 0; k < 8; k++) active_q[c][k] <= '0;
    end else if (commit) begin
      active_q <= shadow_q;
    end
  end

  // R5: unused select slots never become nonzero
  a_r5_spare_slot_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    active_q[rd_ch][7] == '0);
endmodule

// File: rtl/biquad_state.sv
module biquad_state #(
  parameter int NSLOT = 4,
  parameter int DW    = 18,
  parameter int IW    = 2
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [IW-1:0]        rd_idx,
  input  logic [IW-1:0]        prv_idx,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic signed [DW-1:0] wr_x,
  input  logic signed [DW-1:0] wr_y,
  output logic signed [DW-1:0] x1,
  output logic signed [DW-1:0] x2,
  output logic signed [DW-1:0] y1,
  output logic signed [DW-1:0] y2,
  output logic signed [DW-1:0] prv_y
);
  logic signed [DW-1:0] x1_q [NSLOT];
  logic signed [DW-1:0] x2_q [NSLOT];
  logic signed [DW-1:0] y1_q [NSLOT];
  logic signed [DW-1:0] y2_q [NSLOT];

  assign x1    = x1_q[rd_idx];
  assign x2    = x2_q[rd_idx];
  assign y1    = y1_q[rd_idx];
  assign y2    = y2_q[rd_idx];
  assign prv_y = y1_q[prv_idx];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) begin
        x1_q[s] <= '0;
        x2_q[s] <= '0;
        y1_q[s] <= '0;
        y2_q[s] <= '0;
      end
    end else if (wr_en) begin
      x2_q[wr_idx] <= x1_q[wr_idx];
      x1_q[wr_idx] <= wr_x;
      y2_q[wr_idx] <= y1_q[wr_idx];
      y1_q[wr_idx] <= wr_y;
    end
  end

  // R3: write-back never addresses a slot outside the bank
  a_r3_wr_in_range: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |-> (int'(wr_idx) < NSLOT));
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac #(
  parameter int DW   = 18,
  parameter int CW   = 18,
  parameter int AW   = 39,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 sub,
  input  logic signed [CW-1:0] coef,
  input  logic signed [DW-1:0] opnd,
  output logic signed [DW-1:0] y_sat
);
  localparam int PW  = CW + DW;
  localparam int EXT = AW - PW;
  localparam logic signed [AW-1:0] YMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] pext, acc_d, acc_q, scaled;

  assign prod = coef * opnd;
  assign pext = {{EXT{prod[PW-1]}}, prod};

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sub ? (acc_q - pext) : (acc_q + pext);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (clr || en) acc_q <= acc_d;
  end

  assign scaled = acc_q >>> FRAC;

  always_comb begin
    if (scaled > YMAX)      y_sat = YMAX[DW-1:0];
    else if (scaled < YMIN) y_sat = YMIN[DW-1:0];
    else                    y_sat = scaled[DW-1:0];
  end
endmodule

// File: rtl/biquad_engine.sv
module biquad_engine #(
  parameter int NCH  = 2,
  parameter int NSEC = 2,
  parameter int DW   = 18,
  parameter int CW   = 18,
  parameter int FRAC = 14,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NCH*DW-1:0] in_vec,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [CW-1:0]     cfg_val,
  output logic [NCH*DW-1:0] out_vec,
  output logic              out_valid,
  output logic              busy,
  output logic              overrun
);
  import biquad_pkg::*;

  localparam int NSLOT = NCH * NSEC;
  localparam int SW    = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int AW    = DW + CW + 3;
  localparam logic [SW-1:0] SEC_LAST = SW'(NSEC - 1);
  localparam logic [CHW-1:0] CH_LAST = CHW'(NCH - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // sequencer registers
  logic           busy_q, busy_d, pub_q, pub_d, valid_q, valid_d, ovr_q, ovr_d;
  step_e          step_q, step_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [SW-1:0]  sec_q, sec_d;
  logic [IW-1:0]  idx_q, idx_d;

  logic signed [DW-1:0] in_q    [NCH];
  logic signed [DW-1:0] stage_q [NCH];
  logic signed [DW-1:0] out_q   [NCH];

  logic start, run, wb;
  logic signed [DW-1:0] x1, x2, y1, y2, prv_y, x_cur, opnd, y_sec;
  logic signed [CW-1:0] coef;

  assign start = tick && !busy_q;
  assign run   = busy_q && !pub_q;
  assign wb    = run && (step_q == ST_WB);
  assign x_cur = (sec_q == '0) ? in_q[ch_q] : prv_y;

  always_comb begin
    case (step_q)
      ST_B0:   opnd = x_cur;
      ST_B1:   opnd = x1;
      ST_B2:   opnd = x2;
      ST_A1:   opnd = y1;
      ST_A2:   opnd = y2;
      default: opnd = '0;
    endcase
  end

  biquad_coef_bank #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_coef (
    .clk(clk), .rst_ni(rst_i),
    .wr_en(cfg_we), .wr_ch(cfg_ch), .wr_sel(cfg_sel), .wr_val(cfg_val),
    .commit(start), .rd_ch(ch_q), .rd_sel(step_q), .rd_val(coef)
  );

  biquad_state #(.NSLOT(NSLOT), .DW(DW), .IW(IW)) u_state (
    .clk(clk), .rst_ni(rst_i),
    .rd_idx(idx_q), .prv_idx(idx_q - 1'b1),
    .wr_en(wb), .wr_idx(idx_q), .wr_x(x_cur), .wr_y(y_sec),
    .x1(x1), .x2(x2), .y1(y1), .y2(y2), .prv_y(prv_y)
  );

  biquad_mac #(.DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst_ni(rst_i),
    .clr(start || wb), .en(run && (step_q != ST_WB)),
    .sub((step_q == ST_A1) || (step_q == ST_A2)),
    .coef(coef), .opnd(opnd), .y_sat(y_sec)
  );

  // next state
  always_comb begin
    busy_d  = busy_q;
    pub_d   = pub_q;
    step_d  = step_q;
    ch_d    = ch_q;
    sec_d   = sec_q;
    idx_d   = idx_q;
    valid_d = busy_q && pub_q;
    ovr_d   = tick && busy_q;
    if (start) begin
      busy_d = 1'b1;
      pub_d  = 1'b0;
      step_d = ST_B0;
      ch_d   = '0;
      sec_d  = '0;
      idx_d  = '0;
    end else if (run) begin
      if (step_q != ST_WB) begin
        step_d = step_e'(step_q + 3'd1);
      end else begin
        step_d = ST_B0;
        idx_d  = idx_q + 1'b1;
        if (sec_q == SEC_LAST) begin
          sec_d = '0;
          if (ch_q == CH_LAST) pub_d = 1'b1;
          else                 ch_d  = ch_q + 1'b1;
        end else begin
          sec_d = sec_q + 1'b1;
        end
      end
    end else if (pub_q) begin
      busy_d = 1'b0;
      pub_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      busy_q  <= 1'b0;
      pub_q   <= 1'b0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      step_q  <= ST_B0;
      ch_q    <= '0;
      sec_q   <= '0;
      idx_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      pub_q   <= pub_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
      step_q  <= step_d;
      ch_q    <= ch_d;
      sec_q   <= sec_d;
      idx_q   <= idx_d;
    end
  end

  // sample capture, per-channel staging and publish
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      for (int c = 0; c < NCH; c++) begin
        in_q[c]    <= '0;
        stage_q[c] <= '0;
        out_q[c]   <= '0;
      end
    end else begin
      if (start)
        for (int c = 0; c < NCH; c++) in_q[c] <= in_vec[c*DW +: DW];
      if (wb && (sec_q == SEC_LAST)) stage_q[ch_q] <= y_sec;
      if (pub_q) out_q <= stage_q;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign out_vec[g*DW +: DW] = out_q[g];
  end

  assign out_valid = valid_q;
  assign busy      = busy_q;
  assign overrun   = ovr_q;

  // R6: busy only drops together with the publish pulse
  a_r6_valid_ends_busy: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(busy_q) |-> valid_q);
  // R6: output vector holds between publishes
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !valid_q |-> $stable(out_vec));
  // R7: overrun only follows a strobe seen while busy
  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_i)
    ovr_q |-> $past(tick && busy_q));
  // R3: slot counter stays aligned with channel and section counters
  a_r3_slot_sync: assert property (@(posedge clk) disable iff (!rst_i)
    run |-> (int'(idx_q) == int'(ch_q) * NSEC + int'(sec_q)));
endmodule

// File: tb/biquad_engine_test.sv
module biquad_engine_test;
  localparam int NCH = 2, NSEC = 2, DW = 18, CW = 18, FRAC = 14, CHW = 1;
  localparam int BUSY_LEN = NCH * NSEC * 6 + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tick, cfg_we, out_valid, busy, overrun;
  logic [NCH*DW-1:0] in_vec, out_vec;
  logic [CHW-1:0] cfg_ch;
  logic [2:0] cfg_sel;
  logic [CW-1:0] cfg_val;

  biquad_engine uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_vec(in_vec),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .out_vec(out_vec), .out_valid(out_valid), .busy(busy), .overrun(overrun)
  );

  longint sh [NCH][5];
  longint ac [NCH][5];
  longint mx1 [NCH][NSEC];
  longint mx2 [NCH][NSEC];
  longint my1 [NCH][NSEC];
  longint my2 [NCH][NSEC];
  longint exp_o [NCH];
  int checks = 0, fails = 0;

  task automatic chk(string req, string what, longint got, longint expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
    end
  endtask

  function automatic longint satv(longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic longint outw(int c);
    return longint'($signed(out_vec[c*DW +: DW]));
  endfunction

  // model of one sample, with the active set fixed at the strobe
  task automatic model(longint a0, longint a1v);
    for (int c = 0; c < NCH; c++) begin
      longint x, acc, y;
      x = (c == 0) ? a0 : a1v;
      for (int s = 0; s < NSEC; s++) begin
        acc = ac[c][0]*x + ac[c][1]*mx1[c][s] + ac[c][2]*mx2[c][s]
            - ac[c][3]*my1[c][s] - ac[c][4]*my2[c][s];
        y = satv(acc >>> FRAC);
        mx2[c][s] = mx1[c][s]; mx1[c][s] = x;
        my2[c][s] = my1[c][s]; my1[c][s] = y;
        x = y;
      end
      exp_o[c] = x;
    end
  endtask

  task automatic wr(int c, int sel, longint v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(c); cfg_sel = 3'(sel); cfg_val = CW'(v);
    if (sel < 5) sh[c][sel] = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_sample(longint a0, longint a1v);
    @(negedge clk);
    tick = 1'b1;
    in_vec[DW-1:0] = DW'(a0);
    in_vec[2*DW-1:DW] = DW'(a1v);
    ac = sh;
    model(a0, a1v);
    @(negedge clk);
    tick = 1'b0;
  endtask

  // waits out the walk; checks busy length (R6) if asked, then the outputs
  task automatic end_sample(string req, bit len_chk);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    if (len_chk) chk("R6", "busy cycles", n, BUSY_LEN);
    chk("R6", "out_valid at busy fall", out_valid, 1);
    for (int c = 0; c < NCH; c++) chk(req, $sformatf("out ch%0d", c), outw(c), exp_o[c]);
    @(negedge clk);
    chk("R6", "out_valid one cycle", out_valid, 0);
  endtask

  function automatic longint pat(int k, int c);
    case (k % 4)
      0: return longint'((k * 7919 + c * 31337) % 262144) - 131072;
      1: return (k % 8 < 4) ? 40000 : -40000;
      2: return longint'(k * 1000 % 60000) - 30000;
      default: return (c == 0) ? 131071 : -131072;
    endcase
  endfunction

  initial begin
    #(4 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      for (int k = 0; k < 5; k++) sh[c][k] = 0;
      for (int s = 0; s < NSEC; s++) begin
        mx1[c][s] = 0; mx2[c][s] = 0; my1[c][s] = 0; my2[c][s] = 0;
      end
    end
    rst_n = 1'b0; tick = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0;
    cfg_val = '0; in_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "out ch0", outw(0), 0);
    chk("R1", "out ch1", outw(1), 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "overrun", overrun, 0);

    // R1 zero coefficients after reset give zero output
    start_sample(5000, -5000);
    end_sample("R1", 1'b1);

    // R2 R3 pass-through cascade at range extremes
    wr(0, 0, 16384); wr(1, 0, 16384);
    start_sample(131071, -131072); end_sample("R3", 1'b1);
    start_sample(-1, 1);           end_sample("R2", 1'b1);

    // R8 independent recursive filters, long run
    wr(0, 0, 1024);  wr(0, 1, 2048);   wr(0, 2, 1024);
    wr(0, 3, -26214); wr(0, 4, 11469);
    wr(1, 0, 12000); wr(1, 1, -24000); wr(1, 2, 12000);
    wr(1, 3, -20000); wr(1, 4, 8000);
    for (int k = 0; k < 100; k++) begin
      start_sample(pat(k, 0), pat(k, 1));
      end_sample("R8", 1'b1);
    end

    // R4 saturation both directions with gain 4
    wr(0, 0, 65536); wr(0, 1, 0); wr(0, 2, 0); wr(0, 3, 0); wr(0, 4, 0);
    start_sample(60000, 100);   end_sample("R4", 1'b1);
    chk("R4", "ch0 clamped high", outw(0), 131071);
    start_sample(-60000, -100); end_sample("R4", 1'b1);
    chk("R4", "ch0 clamped low", outw(0), -131072);

    // R5 select codes 5..7 ignored
    wr(0, 5, 77777); wr(0, 6, -5); wr(1, 7, 12345);
    start_sample(1000, 2000); end_sample("R5", 1'b1);

    // R5 write during a walk does not affect it, applies next sample
    start_sample(3000, 3000);
    wr(0, 0, 8192);
    end_sample("R5", 1'b0);
    start_sample(3000, 3000); end_sample("R5", 1'b1);

    // R7 strobe while busy: ignored, overrun pulse
    start_sample(-2500, 7000);
    @(negedge clk); tick = 1'b1; in_vec = '1;
    @(negedge clk); tick = 1'b0;
    chk("R7", "overrun pulse", overrun, 1);
    @(negedge clk);
    chk("R7", "overrun clears", overrun, 0);
    end_sample("R7", 1'b0);

    // R2 R3 more recursive samples after the rejected strobe
    wr(0, 0, 2000); wr(0, 3, -16000); wr(0, 4, 6000);
    for (int k = 0; k < 24; k++) begin
      start_sample(pat(k + 3, 1), pat(k + 7, 0));
      end_sample("R2", 1'b1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule